// File: doc/BRIEF.md
# PCI Express Lane Rate Switch Controller

This block controls the change of signalling speed on one PCI Express lane. It sits between the MAC side of a PIPE-style interface and the clocking logic of the transceiver. The MAC requests a speed with one level input. A rising edge on that input asks for a move from 2.5 Gbps to 5 Gbps, and a falling edge asks for the reverse move. The block drives one rate control output, which feeds both the local clock divider and the receive clock recovery unit. At 5 Gbps every lane clock runs at twice its 2.5 Gbps frequency; for example, the fabric interface clock moves from 125 MHz to 250 MHz.

During a switch, the block holds the transmit and receive phase compensation FIFOs in reset. It then waits for the clocking side to confirm with a done input, and answers the MAC with a single-cycle PHY status pulse. After that pulse it releases the FIFO resets. If the request level changes again while a switch is running, the newest level is kept, and a second switch follows the status pulse directly. A timeout guards the wait for the done input. When it expires, the switch completes anyway and a sticky error flag is set.

Top module: `lane_rate_switch_ctrl`

## Requirements
- R1: While reset is held and after it is released, rate_ctrl_o is 0 (2.5 Gbps), both FIFO resets are 0, phy_status_o is 0 and timeout_err_o is 0.
- R2: In idle, a 0-to-1 change of rate_sel_i sampled at a clock edge sets rate_ctrl_o to 1 (5 Gbps) and raises both FIFO resets after that same edge.
- R3: In idle at 5 Gbps, a 1-to-0 change of rate_sel_i sets rate_ctrl_o to 0 and raises both FIFO resets after that same edge.
- R4: Once a switch has started, phy_status_o stays 0 and the FIFO resets stay 1 until switch_done_i is sampled high. In the cycle after that sample, phy_status_o is 1 for exactly one cycle.
- R5: rate_ctrl_o changes only while the FIFO resets are asserted. The FIFO resets fall only in the cycle after a phy_status_o pulse.
- R6: The level of rate_sel_i seen in the first cycle after reset is not treated as an edge. A level held at 1 through reset starts no switch.
- R7: Edges on rate_sel_i during a switch overwrite a single requested level. After the status pulse, if that level differs from rate_ctrl_o, a new switch starts in the next cycle without dropping the FIFO resets. Otherwise the block returns to idle.
- R8: If switch_done_i is not seen within TIMEOUT_CYCLES cycles of waiting, the status pulse is produced anyway, TIMEOUT_CYCLES+2 cycles after the requesting edge, and timeout_err_o goes to 1 together with it.
- R9: timeout_err_o, once set, stays 1 until reset.
- R10: switch_done_i is ignored while no switch is in progress: it produces no status pulse and no change of rate_ctrl_o.
- R11: tx_fifo_rst_o and rx_fifo_rst_o are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel_i | input | 1 | Requested speed level from the MAC (0 = 2.5 Gbps, 1 = 5 Gbps) |
| switch_done_i | input | 1 | Clocking side reports that the speed change is complete |
| rate_ctrl_o | output | 1 | Speed select to the clock divider and the clock recovery unit |
| tx_fifo_rst_o | output | 1 | Reset of the transmit phase compensation FIFO |
| rx_fifo_rst_o | output | 1 | Reset of the receive phase compensation FIFO |
| phy_status_o | output | 1 | One-cycle completion pulse to the MAC |
| timeout_err_o | output | 1 | Sticky flag: a switch completed by timeout |

## Verification
The assertions check several rules on every cycle. The status pulse never lasts more than one cycle. The rate output moves only under FIFO reset, and the FIFO resets fall only right after a status pulse. The two FIFO resets always match, and the error flag is sticky and rises only with a status pulse. A counter also bounds the time spent with resets held. Some behaviour can only be shown by the bench's scenarios: the direction chosen by each edge, the exact cycle of the timeout completion, the chained second switch after a toggle, the collapse of a double toggle back into idle, and the lack of a switch when the request is held high through reset. The bench's scoreboard checks these by matching each status pulse against the rate and error state it predicts.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SWITCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_STATUS = 2'd3
  } lrs_state_e;

  // The level to aim for: a fresh edge wins over the held request.
  function automatic logic pick_target(input logic edge_seen,
                                       input logic new_level,
                                       input logic held_level);
    return edge_seen ? new_level : held_level;
  endfunction

  // A switch is needed when the aimed level differs from the driven rate.
  function automatic logic needs_switch(input logic target,
                                        input logic current);
    return target != current;
  endfunction

endpackage

// File: rtl/lrs_edge_detect.sv
module lrs_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic edge_o
);
  logic level_q;
  logic primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      level_q  <= level_i;
      primed_q <= 1'b1;
    end
  end

  // The first cycle after reset has no valid previous sample.
  assign edge_o = primed_q && (level_i != level_q);

endmodule

// File: rtl/lrs_request_latch.sv
module lrs_request_latch
  import lrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic level_i,
  output logic target_o
);
  logic held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (edge_i) begin
      held_q <= level_i;
    end
  end

  assign target_o = pick_target(edge_i, level_i, held_q);

endmodule

// File: rtl/lrs_wait_timer.sv
module lrs_wait_timer #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
  import lrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic target_i,
  input  logic done_i,
  input  logic expire_i,
  output logic rate_o,
  output logic fifo_rst_o,
  output logic status_o,
  output logic waiting_o,
  output logic err_o
);
  lrs_state_e state_q;
  logic       rate_q;
  logic       err_q;
  logic       want_switch;

  assign want_switch = needs_switch(target_i, rate_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rate_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (want_switch) begin
            state_q <= ST_SWITCH;
            rate_q  <= target_i;
          end
        end
        ST_SWITCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (done_i) begin
            state_q <= ST_STATUS;
          end else if (expire_i) begin
            state_q <= ST_STATUS;
            err_q   <= 1'b1;
          end
        end
        ST_STATUS: begin
          if (want_switch) begin
            state_q <= ST_SWITCH;
            rate_q  <= target_i;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rate_o     = rate_q;
  assign err_o      = err_q;
  assign fifo_rst_o = (state_q != ST_IDLE);
  assign status_o   = (state_q == ST_STATUS);
  assign waiting_o  = (state_q == ST_WAIT);

endmodule

// File: rtl/lane_rate_switch_ctrl.sv
module lane_rate_switch_ctrl #(
  parameter int unsigned TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel_i,
  input  logic switch_done_i,
  output logic rate_ctrl_o,
  output logic tx_fifo_rst_o,
  output logic rx_fifo_rst_o,
  output logic phy_status_o,
  output logic timeout_err_o
);
  // Named internal events, visible to the bound checker.
  logic rate_edge;
  logic rate_target;
  logic wait_active;
  logic wait_expire;
  logic fifo_rst;

  lrs_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(rate_sel_i),
    .edge_o (rate_edge)
  );

  lrs_request_latch u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_i  (rate_edge),
    .level_i (rate_sel_i),
    .target_o(rate_target)
  );

  lrs_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (wait_active),
    .expire_o(wait_expire)
  );

  lrs_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .target_i  (rate_target),
    .done_i    (switch_done_i),
    .expire_i  (wait_expire),
    .rate_o    (rate_ctrl_o),
    .fifo_rst_o(fifo_rst),
    .status_o  (phy_status_o),
    .waiting_o (wait_active),
    .err_o     (timeout_err_o)
  );

  assign tx_fifo_rst_o = fifo_rst;
  assign rx_fifo_rst_o = fifo_rst;

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int unsigned LIMIT = 4096
) (
  input logic clk,
  input logic rst_n,
  input logic rate_ctrl,
  input logic tx_rst,
  input logic rx_rst,
  input logic phy_status,
  input logic err,
  input logic sw_done,
  input logic wait_expire
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_rst || phy_status) busy_cnt <= 0;
    else busy_cnt <= busy_cnt + 1;
  end

  assert_status_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_status |=> !phy_status);

  assert_status_under_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_status |-> tx_rst);

  assert_rate_moves_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_ctrl) |-> tx_rst);

  assert_release_after_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_rst) |-> $past(phy_status));

  assert_expire_completes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expire && !sw_done |=> phy_status && err);

  assert_switch_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= LIMIT + 1);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_err_with_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> phy_status);

  assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done && !tx_rst |=> !phy_status);

  assert_fifo_resets_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst == rx_rst);

endmodule

bind lane_rate_switch_ctrl lrs_checker #(.LIMIT(TIMEOUT_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rate_ctrl  (rate_ctrl_o),
  .tx_rst     (tx_fifo_rst_o),
  .rx_rst     (rx_fifo_rst_o),
  .phy_status (phy_status_o),
  .err        (timeout_err_o),
  .sw_done    (switch_done_i),
  .wait_expire(wait_expire)
);

// File: tb/lane_rate_switch_ctrl_bench.sv
module lane_rate_switch_ctrl_bench;
  localparam int unsigned T = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_sel = 1'b0;
  logic sw_done = 1'b0;
  logic rate_ctrl, tx_rst, rx_rst, phy_status, err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [1:0] exp_q[$];  // {expected rate, expected error flag} per status pulse

  always #5 clk = ~clk;

  lane_rate_switch_ctrl #(.TIMEOUT_CYCLES(T)) u_lane_rate_switch_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rate_sel_i   (rate_sel),
    .switch_done_i(sw_done),
    .rate_ctrl_o  (rate_ctrl),
    .tx_fifo_rst_o(tx_rst),
    .rx_fifo_rst_o(rx_rst),
    .phy_status_o (phy_status),
    .timeout_err_o(err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_pulse();
    sw_done = 1'b1;
    step(1);
    sw_done = 1'b0;
  endtask

  // Monitor: every status pulse is matched against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && phy_status) begin
      if (exp_q.size() == 0) begin
        chk("R4", "unexpected status pulse", 1, 0);
      end else begin
        logic [1:0] item;
        item = exp_q.pop_front();
        chk("R4", "rate at status", int'(rate_ctrl), int'(item[1]));
        chk("R8", "error at status", int'(err), int'(item[0]));
        chk("R11", "rx reset at status", int'(rx_rst), int'(tx_rst));
      end
    end
  end

  initial begin
    int cyc;
    // R1 reset state
    step(3);
    chk("R1", "rate in reset", int'(rate_ctrl), 0);
    chk("R1", "fifo reset in reset", int'(tx_rst), 0);
    chk("R1", "status in reset", int'(phy_status), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1", "rate after reset", int'(rate_ctrl), 0);
    chk("R1", "error after reset", int'(err), 0);

    // R2 rise
    exp_q.push_back(2'b10);
    rate_sel = 1'b1;
    step(1);
    chk("R2", "rate after rise", int'(rate_ctrl), 1);
    chk("R2", "tx reset after rise", int'(tx_rst), 1);
    chk("R11", "rx reset after rise", int'(rx_rst), 1);
    step(5);
    chk("R4", "no status while waiting", int'(phy_status), 0);
    chk("R4", "reset held while waiting", int'(tx_rst), 1);
    done_pulse();
    chk("R4", "status after done", int'(phy_status), 1);
    step(1);
    chk("R4", "status one cycle", int'(phy_status), 0);
    chk("R5", "reset released", int'(tx_rst), 0);

    // R3 fall
    exp_q.push_back(2'b00);
    rate_sel = 1'b0;
    step(1);
    chk("R3", "rate after fall", int'(rate_ctrl), 0);
    chk("R3", "reset after fall", int'(tx_rst), 1);
    step(3);
    done_pulse();
    step(1);
    chk("R5", "reset released after fall", int'(tx_rst), 0);

    // R10 done in idle
    done_pulse();
    chk("R10", "no status on idle done", int'(phy_status), 0);
    step(1);
    chk("R10", "rate unchanged", int'(rate_ctrl), 0);
    chk("R10", "no reset on idle done", int'(tx_rst), 0);

    // R7 single toggle during switch: chained second switch
    exp_q.push_back(2'b10);
    exp_q.push_back(2'b00);
    rate_sel = 1'b1;
    step(3);
    rate_sel = 1'b0;
    step(2);
    done_pulse();
    step(1);
    chk("R7", "second switch rate", int'(rate_ctrl), 0);
    chk("R7", "reset kept across chain", int'(tx_rst), 1);
    step(2);
    done_pulse();
    step(1);
    chk("R7", "released after chain", int'(tx_rst), 0);

    // R7 double toggle collapses
    exp_q.push_back(2'b10);
    rate_sel = 1'b1;
    step(2);
    rate_sel = 1'b0;
    step(1);
    rate_sel = 1'b1;
    step(1);
    done_pulse();
    step(1);
    chk("R7", "idle after double toggle", int'(tx_rst), 0);
    chk("R7", "rate after double toggle", int'(rate_ctrl), 1);

    // R8 timeout
    exp_q.push_back(2'b01);
    rate_sel = 1'b0;
    cyc = 0;
    for (int i = 0; i < int'(T) + 10; i++) begin
      step(1);
      cyc++;
      if (phy_status) break;
    end
    chk("R8", "timeout completion cycle", cyc, int'(T) + 2);
    chk("R8", "error set", int'(err), 1);
    step(1);
    chk("R9", "error sticky", int'(err), 1);
    exp_q.push_back(2'b11);
    rate_sel = 1'b1;
    step(3);
    done_pulse();
    step(1);
    chk("R9", "error still set", int'(err), 1);
    chk("R5", "released after timeout run", int'(tx_rst), 0);

    // R6 level held high through reset
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(10);
    chk("R9", "error cleared by reset", int'(err), 0);
    chk("R6", "no switch on held level", int'(tx_rst), 0);
    chk("R6", "rate stays low", int'(rate_ctrl), 0);
    rate_sel = 1'b0;
    step(2);
    chk("R6", "fall to current rate no switch", int'(tx_rst), 0);
    exp_q.push_back(2'b10);
    rate_sel = 1'b1;
    step(1);
    chk("R2", "rise after reset", int'(rate_ctrl), 1);
    step(2);
    done_pulse();
    step(2);
    chk("R4", "scoreboard drained", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule